// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block holds the ownership state for a memory-mapped host interface that five software localities share. Each locality reaches the interface through its own 4 KB address window, and each window has a one-byte ownership register at its base. Through that register, software in a locality can ask for the interface, find out whether it currently holds it, see whether other localities are waiting, and hand the interface back.

At most one locality is active at any time. When no locality owns the interface and requests are outstanding, the block grants the interface to the highest-numbered requester one clock later. A release write takes effect on the next clock. A grant is only considered once nothing is active, so every release is followed by at least one cycle with no owner. Every change of owner raises a one-cycle ownership-change pulse, which the interrupt status logic consumes.

The bus side is a simple register port: an address, a byte of write data and a write strobe. Read data is decoded combinationally from the address.

Top module: `locality_owner_arb`

## Requirements
- R1: After reset no locality is active, no request is outstanding, `owner_change` is low, and every ownership register reads 0x80.
- R2: The locality number is `bus_addr[14:12]`, and the ownership register is at offset 0 (`bus_addr[11:0]` = 0). A write to locality 5, 6 or 7, or to any nonzero offset, has no effect. A read from any of those addresses returns 0x00.
- R3: Bit 7 of every ownership register of localities 0 to 4 always reads 1.
- R4: A write with bit 1 set, from a locality that is not active, records an outstanding request for that locality. Bit 1 of a register reads 1 while that locality's own request is outstanding.
- R5: When no locality is active and at least one request is outstanding, the highest-numbered requester becomes active after the next clock edge, and its request is cleared.
- R6: Bit 5 reads 1 only in the register of the active locality. `owner_valid` and `owner_id` report the same owner.
- R7: A write with bit 5 set, from the active locality, makes the interface ownerless after the next clock edge. The same write from any other locality has no effect on ownership.
- R8: A write with bit 1 set, from the active locality, is ignored and leaves no request behind.
- R9: Bit 2 reads 1 in the active locality's register exactly when some other locality has a request outstanding. Bit 2 reads 0 in every other register.
- R10: `owner_change` is high for exactly one cycle, the first cycle in which a new grant or a release is visible on `owner_valid` and `owner_id`. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 15 | Register address; locality in bits 14:12 |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| owner_valid | output | 1 | A locality currently owns the interface |
| owner_id | output | 3 | Number of the owning locality |
| owner_change | output | 1 | One-cycle pulse on every grant and release |

## Verification
The bench tries every holder from 0 to 4 together with every subset of the other four localities as waiting requesters. This shows whether the highest-numbered waiter wins after a release, and whether the pending flag appears only in the holder's register. In each run, the holder also writes a request to itself, which separates an ignored request from one that would be granted again after the release. A waiting locality also writes a release, which separates a foreign release that has no effect from a real one. Writes aimed at the unused localities and at nonzero offsets show whether the address decode lets any of them reach the ownership state.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
    // Bit positions inside a locality's ownership register.
    localparam int unsigned OWN_VALID_BIT  = 7;
    localparam int unsigned OWN_ACTIVE_BIT = 5;
    localparam int unsigned OWN_WAIT_BIT   = 2;
    localparam int unsigned OWN_ASK_BIT    = 1;
    localparam int unsigned OWN_REG_W      = 8;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_LSB = 12,
    parameter int unsigned LOC_W   = 3,
    localparam int unsigned ADDR_W = LOC_LSB + LOC_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [LOC_W-1:0]   loc_idx,
    output logic               reg_hit,
    output logic [NUM_LOC-1:0] loc_sel
);
    logic in_range;
    logic at_base;

    assign loc_idx  = addr[LOC_LSB +: LOC_W];
    assign in_range = (loc_idx < LOC_W'(NUM_LOC));
    assign at_base  = (addr[LOC_LSB-1:0] == '0);
    assign reg_hit  = in_range && at_base;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_sel
        assign loc_sel[g] = reg_hit && (loc_idx == LOC_W'(g));
    end
endmodule

// File: rtl/loc_request_bank.sv
module loc_request_bank #(
    parameter int unsigned NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] set_vec,
    input  logic [NUM_LOC-1:0] clr_vec,
    output logic [NUM_LOC-1:0] req_q
);
    typedef struct packed {
        logic [NUM_LOC-1:0] req;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A grant in the same cycle wins over a new request bit.
        st_d.req = (st_q.req | set_vec) & ~clr_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;
endmodule

// File: rtl/loc_owner_ctrl.sv
module loc_owner_ctrl #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] req_vec,
    input  logic               release_hit,
    output logic               own_valid,
    output logic [LOC_W-1:0]   own_id,
    output logic [NUM_LOC-1:0] own_sel,
    output logic [NUM_LOC-1:0] grant_vec,
    output logic               change
);
    typedef struct packed {
        logic             valid;
        logic [LOC_W-1:0] id;
        logic             evt;
    } owner_t;

    owner_t             st_d, st_q;
    logic [LOC_W-1:0]   pick;
    logic               any_req;

    // Highest-numbered requester: later loop iterations override earlier ones.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_vec[i]) begin
                pick = LOC_W'(i);
            end
        end
    end

    assign any_req = |req_vec;

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        grant_vec = '0;
        if (st_q.valid) begin
            if (release_hit) begin
                st_d.valid = 1'b0;
                st_d.evt   = 1'b1;
            end
        end else if (any_req) begin
            st_d.valid      = 1'b1;
            st_d.id         = pick;
            st_d.evt        = 1'b1;
            grant_vec[pick] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_own
        assign own_sel[g] = st_q.valid && (st_q.id == LOC_W'(g));
    end

    assign own_valid = st_q.valid;
    assign own_id    = st_q.id;
    assign change    = st_q.evt;
endmodule

// File: rtl/loc_readback.sv
module loc_readback
    import loc_arb_pkg::*;
#(
    parameter int unsigned NUM_LOC = 5
) (
    input  logic                 reg_hit,
    input  logic [NUM_LOC-1:0]   loc_sel,
    input  logic [NUM_LOC-1:0]   req_vec,
    input  logic [NUM_LOC-1:0]   own_sel,
    output logic [OWN_REG_W-1:0] rdata
);
    logic [NUM_LOC-1:0] others_wait;

    // For each locality: does any other locality have a request outstanding?
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_wait
        logic [NUM_LOC-1:0] mask;
        always_comb begin
            mask    = '1;
            mask[g] = 1'b0;
        end
        assign others_wait[g] = |(req_vec & mask);
    end

    always_comb begin
        rdata = '0;
        if (reg_hit) begin
            rdata[OWN_VALID_BIT]  = 1'b1;
            rdata[OWN_ACTIVE_BIT] = |(loc_sel & own_sel);
            rdata[OWN_WAIT_BIT]   = |(loc_sel & own_sel & others_wait);
            rdata[OWN_ASK_BIT]    = |(loc_sel & req_vec);
        end
    end
endmodule

// File: rtl/locality_owner_arb.sv
module locality_owner_arb
    import loc_arb_pkg::*;
#(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_LSB = 12,
    parameter int unsigned LOC_W   = 3,
    localparam int unsigned ADDR_W = LOC_LSB + LOC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [OWN_REG_W-1:0] bus_wdata,
    input  logic                 bus_we,
    output logic [OWN_REG_W-1:0] bus_rdata,
    output logic                 owner_valid,
    output logic [LOC_W-1:0]     owner_id,
    output logic                 owner_change
);
    logic [LOC_W-1:0]   loc_idx;
    logic               reg_hit;
    logic [NUM_LOC-1:0] loc_sel;
    logic [NUM_LOC-1:0] req_q;
    logic [NUM_LOC-1:0] own_sel;
    logic [NUM_LOC-1:0] grant_vec;
    logic [NUM_LOC-1:0] wr_sel;
    logic [NUM_LOC-1:0] ask_set;
    logic               release_hit;

    loc_addr_decode #(
        .NUM_LOC (NUM_LOC),
        .LOC_LSB (LOC_LSB),
        .LOC_W   (LOC_W)
    ) i_decode (
        .addr    (bus_addr),
        .loc_idx (loc_idx),
        .reg_hit (reg_hit),
        .loc_sel (loc_sel)
    );

    assign wr_sel      = bus_we ? loc_sel : '0;
    // A request from the current owner is dropped.
    assign ask_set     = bus_wdata[OWN_ASK_BIT] ? (wr_sel & ~own_sel) : '0;
    // Only the owner's own window can give ownership back.
    assign release_hit = bus_wdata[OWN_ACTIVE_BIT] && |(wr_sel & own_sel);

    loc_request_bank #(
        .NUM_LOC (NUM_LOC)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ask_set),
        .clr_vec (grant_vec),
        .req_q   (req_q)
    );

    loc_owner_ctrl #(
        .NUM_LOC (NUM_LOC),
        .LOC_W   (LOC_W)
    ) i_owner (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vec     (req_q),
        .release_hit (release_hit),
        .own_valid   (owner_valid),
        .own_id      (owner_id),
        .own_sel     (own_sel),
        .grant_vec   (grant_vec),
        .change      (owner_change)
    );

    loc_readback #(
        .NUM_LOC (NUM_LOC)
    ) i_read (
        .reg_hit (reg_hit),
        .loc_sel (loc_sel),
        .req_vec (req_q),
        .own_sel (own_sel),
        .rdata   (bus_rdata)
    );

    // loc_idx is only needed by the decoder's own qualification.
    logic unused_idx;
    assign unused_idx = ^loc_idx;
endmodule

// File: rtl/locality_owner_arb_chk.sv
module locality_owner_arb_chk #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned LOC_LSB = 12,
    parameter int unsigned LOC_W   = 3,
    localparam int unsigned ADDR_W = LOC_LSB + LOC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic [7:0]        bus_rdata,
    input logic              owner_valid,
    input logic [LOC_W-1:0]  owner_id,
    input logic              owner_change
);
    logic [LOC_W-1:0] a_loc;
    logic             a_base;
    logic             a_inrange;

    assign a_loc     = bus_addr[LOC_LSB +: LOC_W];
    assign a_base    = (bus_addr[LOC_LSB-1:0] == '0);
    assign a_inrange = (a_loc < LOC_W'(NUM_LOC));

    // R6
    owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_valid |-> (owner_id < LOC_W'(NUM_LOC)));

    // R3
    valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_base && a_inrange) |-> bus_rdata[7]);

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_base && a_inrange) |-> (bus_rdata == 8'h00));

    // R6
    active_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_base && a_inrange && bus_rdata[5]) |-> (owner_valid && owner_id == a_loc));

    // R7
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[5] && owner_valid && a_loc != owner_id)
        |=> (owner_valid && owner_id == $past(owner_id)));

    // R10
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_change |-> (owner_valid != $past(owner_valid)));

    // R5
    grant_follows_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && !$past(owner_valid)) |-> owner_change);
endmodule

bind locality_owner_arb locality_owner_arb_chk #(
    .NUM_LOC (NUM_LOC),
    .LOC_LSB (LOC_LSB),
    .LOC_W   (LOC_W)
) i_locality_owner_arb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_rdata    (bus_rdata),
    .owner_valid  (owner_valid),
    .owner_id     (owner_id),
    .owner_change (owner_change)
);

// File: tb/test_locality_owner_arb.sv
`timescale 1ns/1ps
module test_locality_owner_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        owner_valid;
    logic [2:0]  owner_id;
    logic        owner_change;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side expectation state.
    logic [4:0] m_req;
    logic       m_act;
    logic [2:0] m_id;
    logic       m_evt;

    always #2.5 clk = ~clk;

    locality_owner_arb i_locality_owner_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_rdata    (bus_rdata),
        .owner_valid  (owner_valid),
        .owner_id     (owner_id),
        .owner_change (owner_change)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] reg_addr(input int loc, input int off);
        return 15'((loc << 12) | off);
    endfunction

    function automatic int exp_read(input logic [14:0] a);
        int loc;
        int v;
        loc = int'(a[14:12]);
        if (loc >= 5 || a[11:0] != 0) return 0;
        v = 8'h80;
        if (m_act && m_id == 3'(loc)) begin
            v |= 8'h20;
            if ((m_req & ~(5'b1 << loc)) != 0) v |= 8'h04;
        end
        if (m_req[loc]) v |= 8'h02;
        return v;
    endfunction

    // One clock: drive, update expectations at the edge, then compare ports.
    task automatic tick(input logic [14:0] a, input logic [7:0] d, input logic we);
        int  loc;
        bit  hit, mine, ask, rel;
        logic [4:0] nreq;
        bus_addr = a; bus_wdata = d; bus_we = we;
        @(posedge clk);
        loc  = int'(a[14:12]);
        hit  = we && loc < 5 && a[11:0] == 0;
        mine = m_act && m_id == 3'(loc);
        ask  = hit && d[1] && !mine;
        rel  = hit && d[5] && mine;
        nreq = m_req;
        if (ask) nreq[loc] = 1'b1;
        m_evt = 1'b0;
        if (m_act) begin
            if (rel) begin m_act = 1'b0; m_evt = 1'b1; end
        end else if (m_req != 0) begin
            for (int i = 0; i < 5; i++) if (m_req[i]) m_id = 3'(i);
            m_act = 1'b1; m_evt = 1'b1;
            nreq[m_id] = 1'b0;
        end
        m_req = nreq;
        @(negedge clk);
        bus_we = 1'b0;
        check("R6 owner_valid", int'(owner_valid), int'(m_act));
        if (m_act) check("R5 owner_id", int'(owner_id), int'(m_id));
        check("R10 owner_change", int'(owner_change), int'(m_evt));
    endtask

    task automatic read_all(input string tag);
        for (int l = 0; l < 8; l++) begin
            bus_addr = reg_addr(l, 0);
            #0.2;
            check({tag, " R3 R4 R9 read"}, int'(bus_rdata), exp_read(bus_addr));
        end
        bus_addr = reg_addr(1, 12'h018);
        #0.2;
        check("R2 offset read", int'(bus_rdata), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_req = '0; m_act = 1'b0; m_id = '0; m_evt = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check("R1 owner_valid", int'(owner_valid), 0);
        check("R1 owner_change", int'(owner_change), 0);
        for (int l = 0; l < 5; l++) begin
            bus_addr = reg_addr(l, 0);
            #0.2;
            check("R1 reset read", int'(bus_rdata), 8'h80);
        end

        // R2: unmapped writes must not start any request.
        for (int l = 5; l < 8; l++) tick(reg_addr(l, 0), 8'h22, 1'b1);
        tick(reg_addr(2, 12'h004), 8'h02, 1'b1);
        tick(reg_addr(3, 12'h800), 8'h02, 1'b1);
        tick(reg_addr(0, 0), 8'h00, 1'b0);
        check("R2 no owner after unmapped writes", int'(owner_valid), 0);
        read_all("R2");

        // Sweep: every holder with every subset of waiters.
        for (int h = 0; h < 5; h++) begin
            for (int mask = 0; mask < 32; mask++) begin
                int lowest;
                if (mask[h]) continue;
                do_reset();
                tick(reg_addr(h, 0), 8'h02, 1'b1);          // R4
                read_all("R4");
                tick(reg_addr(h, 0), 8'h00, 1'b0);          // R5 grant
                check("R5 holder granted", int'(owner_id), h);
                lowest = -1;
                for (int w = 0; w < 5; w++) begin
                    if (mask[w]) begin
                        if (lowest < 0) lowest = w;
                        tick(reg_addr(w, 0), 8'h02, 1'b1);
                    end
                end
                read_all("R9");
                tick(reg_addr(h, 0), 8'h02, 1'b1);          // R8 self request
                read_all("R8");
                if (lowest >= 0) begin
                    tick(reg_addr(lowest, 0), 8'h20, 1'b1); // R7 foreign release
                    check("R7 foreign release ignored", int'(owner_id), h);
                end
                tick(reg_addr(h, 0), 8'h20, 1'b1);          // R7 release
                check("R7 released", int'(owner_valid), 0);
                tick(reg_addr(0, 0), 8'h00, 1'b0);
                if (mask == 0) check("R8 no regrant", int'(owner_valid), 0);
                read_all("R5");
                // Drain remaining waiters through repeated releases.
                for (int k = 0; k < 6 && m_act; k++) begin
                    tick(reg_addr(int'(m_id), 0), 8'h20, 1'b1);
                    tick(reg_addr(0, 0), 8'h00, 1'b0);
                end
                check("R5 all served", int'(owner_valid), 0);
            end
        end

        // Combined write from a waiter: request plus release bit.
        do_reset();
        tick(reg_addr(1, 0), 8'h02, 1'b1);
        tick(reg_addr(0, 0), 8'h00, 1'b0);
        tick(reg_addr(4, 0), 8'h22, 1'b1);
        read_all("R4 R7 combined");
        tick(reg_addr(1, 0), 8'h22, 1'b1);
        tick(reg_addr(0, 0), 8'h00, 1'b0);
        check("R5 waiter wins", int'(owner_id), 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule